// File: doc/BRIEF.md
# Indirect-Access NIC Control Register File

This block is the bus-side control register bank of a network controller. It holds a small set of 16-bit registers behind only two word locations. One location is a register pointer and the other is a data window onto whichever register the pointer selects. Software first writes the pointer, then reads or writes through the data window.

Register 0 is the main control/status register, and its bits do not all behave alike:
- Some bits are event flags that software clears by writing a one.
- Two summary bits are recomputed on each write.
- The interrupt-enable bit simply follows the written value.
- The low bits act as start, init and stop commands. Stop overrides everything else, and init takes precedence over start.

Registers 1 and 2 together form a 32-bit initialization pointer presented on an output port. Register 3 is plain storage. The interrupt request is a level output driven from the status register.

The bus is a simple synchronous word-wide register port: a byte address, a write strobe, write data, and combinational read data. The word offset is the byte address shifted right by one. Writes take effect at the rising clock edge on which `bus_wr` is high. There is no handshake, so the block never applies back-pressure.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset the status register reads 0x0004 (only the stop bit set), the pointer reads 0 and `irq` is low.
- R2: A write to word offset 1 loads the pointer only when the written value is less than NREGS (4). Otherwise the pointer keeps its value. Reading offset 1 returns the pointer, zero-extended.
- R3: Word offset 0 reads and writes the register selected by the pointer. Registers 1 to 3 store the written value unchanged.
- R4: A status write with bit 2 set leaves the status register equal to exactly 0x0004, and every other effect of that write is discarded.
- R5: On a status write without bit 2, each written 1 in bits 14..8 clears that status bit. Bits 14..8 written as 0 keep their value, and bits 3..0 not affected by a command keep their value.
- R6: On such a write, bit 15 becomes the OR of bits 14, 13, 12 and 8, and bit 7 becomes the OR of bits 14..8. Both are taken after the clears and before that write's command bits are applied.
- R7: On such a write, bit 6 (interrupt enable) takes the written bit 6.
- R8: On such a write, writing bit 0 (init) sets bits 0 and 8 and clears bit 2. Otherwise, writing bit 1 (start) sets bits 1, 4 and 5 and clears bit 2. Init takes precedence over start.
- R9: `init_ptr` equals register 2 in bits 31..16 and register 1 in bits 15..0.
- R10: `irq` is high exactly when status bits 7 and 6 are both set.
- R11: Word offsets 2 and 3 read as 0, and writes to them change no register and not the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address; word offset is bus_addr[2:1] |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| init_ptr | output | 32 | Initialization pointer {reg2, reg1} |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that `bus_wr` is low throughout reset and on the first clock after it. They also assume the address and data are stable around each rising edge. The bench meets both conditions by driving every input on the falling edge and holding the strobe low until reset has been released.

Only the init command can set a flag in bits 14..8, because no event source is in scope. The write-one-to-clear and summary checks therefore rely on bit 8 set by init. A long pseudo-random write sequence covers the stop, init and start combinations, and each value read back is compared with an arithmetic model in the bench.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
  localparam int unsigned DW = 16;

  localparam int unsigned BIT_ERR  = 15;
  localparam int unsigned BIT_INTR = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_RXON = 5;
  localparam int unsigned BIT_TXON = 4;
  localparam int unsigned BIT_STOP = 2;
  localparam int unsigned BIT_STRT = 1;
  localparam int unsigned BIT_INIT = 0;
  localparam int unsigned BIT_IDON = 8;

  localparam logic [DW-1:0] MASK_W1C  = 16'h7F00;
  localparam logic [DW-1:0] MASK_ERRS = 16'h7100;
  localparam logic [DW-1:0] STAT_RST  = 16'h0004;

  typedef enum logic [1:0] {
    OFF_DATA = 2'd0,
    OFF_PTR  = 2'd1
  } word_off_e;
endpackage

// File: rtl/nic_ctl_ptr.sv
module nic_ctl_ptr #(
  parameter int unsigned NREGS = 4,
  parameter int unsigned DW    = 16,
  localparam int unsigned PW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr
);
  logic accept;
  assign accept = wr_en && (32'(wdata) < 32'(NREGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (accept) ptr <= wdata[PW-1:0];
  end

  // R2
  ptr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wdata) >= 32'(NREGS))) |=> $stable(ptr));

  // R2
  ptr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wdata) < 32'(NREGS))) |=> (32'(ptr) == 32'($past(wdata))));
endmodule

// File: rtl/nic_ctl_status.sv
module nic_ctl_status
  import nic_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status
);
  logic [DW-1:0] after_clr;
  logic [DW-1:0] nxt;

  always_comb begin
    after_clr = status & ~(wdata & MASK_W1C);
    after_clr[BIT_ERR]  = |(after_clr & MASK_ERRS);
    after_clr[BIT_INTR] = |(after_clr & MASK_W1C);
    after_clr[BIT_IE]   = wdata[BIT_IE];
    nxt = after_clr;
    if (wdata[BIT_INIT]) begin
      nxt[BIT_INIT] = 1'b1;
      nxt[BIT_IDON] = 1'b1;
      nxt[BIT_STOP] = 1'b0;
    end else if (wdata[BIT_STRT]) begin
      nxt[BIT_STRT] = 1'b1;
      nxt[BIT_RXON] = 1'b1;
      nxt[BIT_TXON] = 1'b1;
      nxt[BIT_STOP] = 1'b0;
    end
    if (wdata[BIT_STOP]) nxt = STAT_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= STAT_RST;
    else if (wr_en) status <= nxt;
  end

  // R4
  stop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[BIT_STOP]) |=> (status == STAT_RST));

  // R7
  enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_STOP]) |=> (status[BIT_IE] == $past(wdata[BIT_IE])));

  // R8
  init_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_STOP] && wdata[BIT_INIT])
      |=> (status[BIT_INIT] && status[BIT_IDON] && !status[BIT_STOP]
           && (status[BIT_STRT] == $past(status[BIT_STRT]))));

  // R8
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_STOP] && !wdata[BIT_INIT] && wdata[BIT_STRT])
      |=> (status[BIT_STRT] && status[BIT_RXON] && status[BIT_TXON] && !status[BIT_STOP]));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status));
endmodule

// File: rtl/nic_ctl_cell.sv
module nic_ctl_cell #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

  // R3
  cell_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wdata)));

  // R11
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_ctl_pkg::*;
#(
  parameter int unsigned NREGS = 4,
  parameter int unsigned AW    = 3,
  localparam int unsigned PW   = $clog2(NREGS),
  localparam int unsigned OW   = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [31:0]   init_ptr,
  output logic          irq
);
  logic [OW-1:0] woff;
  logic          unused_lsb;
  logic          sel_data;
  logic          sel_ptr;
  logic [PW-1:0] ptr;
  logic [DW-1:0] rf [NREGS];
  logic [NREGS-1:0] reg_we;

  assign woff       = bus_addr[AW-1:1];
  assign unused_lsb = bus_addr[0];
  assign sel_data   = (32'(woff) == 32'(OFF_DATA));
  assign sel_ptr    = (32'(woff) == 32'(OFF_PTR));

  nic_ctl_ptr #(.NREGS(NREGS), .DW(DW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr && sel_ptr),
    .wdata (bus_wdata),
    .ptr   (ptr)
  );

  for (genvar k = 0; k < NREGS; k++) begin : g_we
    assign reg_we[k] = bus_wr && sel_data && (32'(ptr) == k);
  end

  nic_ctl_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we[0]),
    .wdata  (bus_wdata),
    .status (rf[0])
  );

  for (genvar k = 1; k < NREGS; k++) begin : g_cell
    nic_ctl_cell #(.DW(DW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_we[k]),
      .wdata (bus_wdata),
      .q     (rf[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)     bus_rdata = rf[ptr];
    else if (sel_ptr) bus_rdata = 16'(ptr);
  end

  assign init_ptr = {rf[2], rf[1]};
  assign irq      = rf[0][BIT_INTR] && rf[0][BIT_IE];

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(reg_we[0]));

  // R11
  ptr_offsets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_ptr) |=> $stable(ptr));
endmodule

// File: tb/nic_ctl_regs_bench.sv
`timescale 1ns/1ps
module nic_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] init_ptr;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_stat;
  logic [15:0] m_reg [4];
  logic [1:0]  m_ptr;

  always #2.5 clk = ~clk;

  nic_ctl_regs u_nic_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_ptr(init_ptr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] cur, input logic [15:0] w);
    logic [15:0] r;
    if (w[2]) return 16'h0004;
    r = cur & ~(w & 16'h7F00);
    r[15] = (r[14] | r[13] | r[12] | r[8]);
    r[7]  = |r[14:8];
    r[6]  = w[6];
    if (w[0]) begin r[0] = 1; r[8] = 1; r[2] = 0; end
    else if (w[1]) begin r[1] = 1; r[4] = 1; r[5] = 1; r[2] = 0; end
    return r;
  endfunction

  task automatic stat_wr(input logic [15:0] w, input string req);
    logic [15:0] v;
    m_stat = model_next(m_stat, w);
    wr(3'd0, w);
    rd(3'd0, v);
    chk(req, 32'(v), 32'(m_stat));
    chk("R10 irq", 32'(irq), 32'(m_stat[7] & m_stat[6]));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_stat = 16'h0004; m_ptr = 0;
    for (int k = 0; k < 4; k++) m_reg[k] = 16'h0;

    // R1 reset state
    rd(3'd0, v); chk("R1 status", 32'(v), 32'h0004);
    rd(3'd2, v); chk("R1 ptr", 32'(v), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 pointer sweep including out-of-range values
    for (int p = 0; p < 20; p++) begin
      x = (p < 16) ? 16'(p) : (16'hFFFF - 16'(p));
      wr(3'd2, x);
      if (x < 4) m_ptr = x[1:0];
      rd(3'd2, v); chk("R2 ptr", 32'(v), 32'(m_ptr));
    end

    // R3 / R9 plain registers through the data window
    for (int k = 1; k < 4; k++) begin
      for (int i = 0; i < 6; i++) begin
        x = 16'(k * 16'h1111) ^ 16'(i * 16'h0F3D) ^ (16'h8001 << i);
        wr(3'd2, 16'(k)); m_ptr = 2'(k);
        wr(3'd0, x); m_reg[k] = x;
        rd(3'd0, v); chk("R3 data", 32'(v), 32'(x));
        chk("R9 init_ptr", init_ptr, {m_reg[2], m_reg[1]});
      end
    end

    // R11 unimplemented offsets
    wr(3'd4, 16'h0001); wr(3'd6, 16'hBEEF); wr(3'd5, 16'h0002);
    rd(3'd4, v); chk("R11 off2", 32'(v), 32'h0);
    rd(3'd6, v); chk("R11 off3", 32'(v), 32'h0);
    rd(3'd2, v); chk("R11 ptr kept", 32'(v), 32'(m_ptr));
    for (int k = 1; k < 4; k++) begin
      wr(3'd2, 16'(k)); m_ptr = 2'(k);
      rd(3'd0, v); chk("R11 reg kept", 32'(v), 32'(m_reg[k]));
    end
    wr(3'd2, 16'd0); m_ptr = 0;
    rd(3'd0, v); chk("R11 status kept", 32'(v), 32'(m_stat));

    // Directed status sequence
    stat_wr(16'h0004, "R4 stop");
    stat_wr(16'h0041, "R8 init");              // 0x0141
    stat_wr(16'h0040, "R6 summaries");         // 0x81C1, irq high
    chk("R10 irq high", 32'(irq), 32'h1);
    stat_wr(16'h0100, "R5 w1c");               // 0x0001
    stat_wr(16'h0042, "R8 start");             // 0x0073
    stat_wr(16'hFFFF, "R4 stop all");          // 0x0004
    stat_wr(16'h0003, "R8 init priority");     // 0x0101
    stat_wr(16'h0040, "R7 enable");
    stat_wr(16'h0000, "R7 disable");
    stat_wr(16'h0600, "R5 w1c other");

    // Pseudo-random status sweep against the model
    x = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      if (x[2] && x[7]) stat_wr(x, "R4 sweep");
      else stat_wr(x & ((i % 3 == 0) ? 16'hFFFB : 16'hFF7B),
                   x[0] ? "R8 sweep" : "R5 R6 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule